// File: doc/BRIEF.md
# Dual Interval Timer Unit

This block is the timer peripheral of a small 4-bit microcontroller. A prescaler divides the system clock by six to make a base tick. That tick paces two counters. The first counter is a fixed interval counter. It runs all the time and completes one cycle every 127 ticks. The second counter is an 8-bit up-counter that the CPU can start and stop. When it overflows, it is reloaded from a CPU-written register, and an external pin changes level. Each counter raises its own request flag, and the flag stays set until the CPU clears it.

The CPU writes a 4-bit control register. One bit enables the interrupt line of the fixed counter. Another bit gates the reload counter. The two remaining bits are only stored. The reload value has its own write port. Each flag has a one-cycle clear input. Instruction decode and interrupt vectoring are handled outside this block.

Top module: `dual_interval_timer`

## Requirements
- R1: The base tick fires once every 6 clock cycles. Releasing reset restarts the divider, so the first tick after reset happens at the 6th rising edge.
- R2: The fixed counter is 7 bits wide. It advances on every tick, whatever the control register holds. When its next value would be 127, it goes to 0 instead, so one cycle lasts 127 ticks. After reset, `flag1_o` first rises after rising edge 762.
- R3: Flag 1 is set on the clock edge where the fixed counter wraps.
- R4: The reload counter advances on a tick only while control bit 3 is 1. While bit 3 is 0, `flag2_o` never sets and `tpin_o` never changes.
- R5: When the reload counter rolls over from 255, it loads the stored reload value instead of 0, and flag 2 is set on the same edge. With reload value v, the following overflows are 256−v ticks apart.
- R6: `tpin_o` inverts its level on every overflow of the reload counter, and at no other time.
- R7: `irq1_o` is flag 1 AND control bit 0. `ctrl_o` returns all four control bits as written, taking effect one cycle after the write. Bits 1 and 2 change no timer behaviour.
- R8: A flag stays at 1 until its clear input is high for a cycle. When a set and a clear fall in the same cycle, the flag ends up at 1.
- R9: Reset sets both counters, both flags, the control register, the reload value and `tpin_o` to 0.
- R10: Writing the reload value does not change the current count. The new value is only loaded at the next overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Write strobe for the control register |
| ctrl_wdata_i | input | 4 | New control value: bit 0 enables irq1, bit 3 runs the reload counter |
| reload_we_i | input | 1 | Write strobe for the reload value |
| reload_wdata_i | input | 8 | New reload value |
| clr_flag1_i | input | 1 | One-cycle clear for flag 1 |
| clr_flag2_i | input | 1 | One-cycle clear for flag 2 |
| ctrl_o | output | 4 | Current control register |
| flag1_o | output | 1 | Sticky request from the fixed counter |
| flag2_o | output | 1 | Sticky request from the reload counter |
| irq1_o | output | 1 | Interrupt line for the fixed counter |
| tpin_o | output | 1 | Output pin that toggles on each reload overflow |

## Verification
The properties assume that the clear inputs and write strobes are synchronous to `clk_i` and are stable around each rising edge. They make no assumption about how often these inputs are pulsed. The bench changes its inputs 1 ns after each rising edge and compares the outputs on the falling edge, so every input has settled before the design samples it.

Random reload values are mostly drawn from the top of the 8-bit range. This keeps overflows frequent, and overflows often land close to reload writes and clear pulses. Directed phases then cover:
- the 762-cycle first wrap of the fixed counter;
- a stopped reload counter;
- a reload write made while the counter is running.

// File: rtl/dit_pkg.sv
package dit_pkg;
    localparam int DIT_PRESCALE   = 6;
    localparam int DIT_T1_WIDTH   = 7;
    localparam int DIT_T1_MODULO  = 127;
    localparam int DIT_T2_WIDTH   = 8;
    localparam int DIT_CTRL_WIDTH = 4;
    localparam int DIT_CTRL_IRQ1  = 0;
    localparam int DIT_CTRL_RUN2  = 3;

    typedef struct packed {
        logic flag1;
        logic flag2;
    } dit_flags_t;

    function automatic logic dit_sticky(input logic cur, input logic set, input logic clr);
        return set | (cur & ~clr);
    endfunction
endpackage

// File: rtl/dit_prescaler.sv
module dit_prescaler #(
    parameter int DIV = dit_pkg::DIT_PRESCALE
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = (st_q.cnt == LAST);
endmodule

// File: rtl/dit_fixed_timer.sv
module dit_fixed_timer #(
    parameter int W   = dit_pkg::DIT_T1_WIDTH,
    parameter int MOD = dit_pkg::DIT_T1_MODULO
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    output logic         wrap_o,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] TOP = W'(MOD - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } ft_state_t;

    ft_state_t st_d, st_q;
    logic      at_top;

    always_comb begin
        st_d   = st_q;
        at_top = (st_q.cnt == TOP);
        if (tick_i) begin
            st_d.cnt = at_top ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wrap_o = tick_i & at_top;
    assign cnt_o  = st_q.cnt;
endmodule

// File: rtl/dit_reload_timer.sv
module dit_reload_timer #(
    parameter int W = dit_pkg::DIT_T2_WIDTH
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    input  logic         run_i,
    input  logic [W-1:0] reload_i,
    output logic         ovf_o,
    output logic [W-1:0] cnt_o,
    output logic         pin_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         pin;
    } rt_state_t;

    rt_state_t st_d, st_q;
    logic      step;
    logic      ovf;

    always_comb begin
        st_d = st_q;
        step = tick_i & run_i;
        ovf  = step & (&st_q.cnt);
        if (step) begin
            st_d.cnt = ovf ? reload_i : st_q.cnt + 1'b1;
        end
        if (ovf) begin
            st_d.pin = ~st_q.pin;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ovf_o = ovf;
    assign cnt_o = st_q.cnt;
    assign pin_o = st_q.pin;
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer #(
    parameter int PRESCALE = dit_pkg::DIT_PRESCALE,
    parameter int T1_W     = dit_pkg::DIT_T1_WIDTH,
    parameter int T1_MOD   = dit_pkg::DIT_T1_MODULO,
    parameter int T2_W     = dit_pkg::DIT_T2_WIDTH,
    parameter int CTRL_W   = dit_pkg::DIT_CTRL_WIDTH
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ctrl_we_i,
    input  logic [CTRL_W-1:0] ctrl_wdata_i,
    input  logic              reload_we_i,
    input  logic [T2_W-1:0]   reload_wdata_i,
    input  logic              clr_flag1_i,
    input  logic              clr_flag2_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              flag1_o,
    output logic              flag2_o,
    output logic              irq1_o,
    output logic              tpin_o
);
    import dit_pkg::*;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [T2_W-1:0]   reload;
        dit_flags_t        flags;
    } top_state_t;

    top_state_t       st_d, st_q;
    logic             tick;
    logic             t1_wrap;
    logic [T1_W-1:0]  t1_cnt;
    logic             t2_ovf;
    logic [T2_W-1:0]  t2_cnt;
    logic             t2_run;

    dit_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick)
    );

    dit_fixed_timer #(.W(T1_W), .MOD(T1_MOD)) u_t1 (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tick),
        .wrap_o (t1_wrap),
        .cnt_o  (t1_cnt)
    );

    assign t2_run = st_q.ctrl[DIT_CTRL_RUN2];

    dit_reload_timer #(.W(T2_W)) u_t2 (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick),
        .run_i    (t2_run),
        .reload_i (st_q.reload),
        .ovf_o    (t2_ovf),
        .cnt_o    (t2_cnt),
        .pin_o    (tpin_o)
    );

    always_comb begin
        st_d = st_q;
        if (ctrl_we_i) begin
            st_d.ctrl = ctrl_wdata_i;
        end
        if (reload_we_i) begin
            st_d.reload = reload_wdata_i;
        end
        st_d.flags.flag1 = dit_sticky(st_q.flags.flag1, t1_wrap, clr_flag1_i);
        st_d.flags.flag2 = dit_sticky(st_q.flags.flag2, t2_ovf, clr_flag2_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o  = st_q.ctrl;
    assign flag1_o = st_q.flags.flag1;
    assign flag2_o = st_q.flags.flag2;
    assign irq1_o  = st_q.flags.flag1 & st_q.ctrl[DIT_CTRL_IRQ1];
endmodule

// File: rtl/dit_checker.sv
module dit_checker #(
    parameter int PRESCALE = dit_pkg::DIT_PRESCALE,
    parameter int T2_W     = dit_pkg::DIT_T2_WIDTH
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            tick,
    input logic            t1_wrap,
    input logic            t2_ovf,
    input logic            t2_run,
    input logic [T2_W-1:0] t2_cnt,
    input logic [T2_W-1:0] reload_q,
    input logic            clr_flag1_i,
    input logic            clr_flag2_i,
    input logic            flag1_o,
    input logic            flag2_o,
    input logic            tpin_o
);
    localparam int GW = $clog2(PRESCALE + 1) + 1;
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gap_q <= '0;
        end else if (tick) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick |-> (gap_q == GW'(PRESCALE - 1))); // R1
    AST_TICK_DUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gap_q == GW'(PRESCALE - 1)) |-> tick); // R1
    AST_FLAG1_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        t1_wrap |=> flag1_o); // R3
    AST_T2_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(tick && t2_run) |=> $stable(t2_cnt)); // R4
    AST_T2_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        t2_ovf |=> (t2_cnt == $past(reload_q)) && flag2_o); // R5
    AST_PIN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !t2_ovf |=> $stable(tpin_o)); // R6
    AST_PIN_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        t2_ovf |=> (tpin_o != $past(tpin_o))); // R6
    AST_SET_WINS1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (t1_wrap && clr_flag1_i) |=> flag1_o); // R8
    AST_CLEAR2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_flag2_i && !t2_ovf) |=> !flag2_o); // R8
    AST_STICKY1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag1_o && !clr_flag1_i) |=> flag1_o); // R8
endmodule

bind dual_interval_timer dit_checker #(.PRESCALE(PRESCALE), .T2_W(T2_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick        (tick),
    .t1_wrap     (t1_wrap),
    .t2_ovf      (t2_ovf),
    .t2_run      (t2_run),
    .t2_cnt      (t2_cnt),
    .reload_q    (st_q.reload),
    .clr_flag1_i (clr_flag1_i),
    .clr_flag2_i (clr_flag2_i),
    .flag1_o     (flag1_o),
    .flag2_o     (flag2_o),
    .tpin_o      (tpin_o)
);

// File: tb/dual_interval_timer_tb.sv
module dual_interval_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [3:0] ctrl_wd = '0;
    logic       rl_we = 1'b0;
    logic [7:0] rl_wd = '0;
    logic       clr1 = 1'b0;
    logic       clr2 = 1'b0;
    logic [3:0] ctrl_o;
    logic       flag1, flag2, irq1, tpin;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dual_interval_timer u_dut (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .ctrl_we_i      (ctrl_we),
        .ctrl_wdata_i   (ctrl_wd),
        .reload_we_i    (rl_we),
        .reload_wdata_i (rl_wd),
        .clr_flag1_i    (clr1),
        .clr_flag2_i    (clr2),
        .ctrl_o         (ctrl_o),
        .flag1_o        (flag1),
        .flag2_o        (flag2),
        .irq1_o         (irq1),
        .tpin_o         (tpin)
    );

    // Reference model built from the requirements
    int         m_pre, m_t1, m_t2;
    logic [7:0] m_rl;
    logic [3:0] m_ctrl;
    logic       m_f1, m_f2, m_pin;
    bit         tk, w1, ov;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pre = 0; m_t1 = 0; m_t2 = 0; m_rl = '0; m_ctrl = '0;
            m_f1 = 1'b0; m_f2 = 1'b0; m_pin = 1'b0;
        end else begin
            tk = (m_pre == 5);
            w1 = tk && (m_t1 == 126);
            ov = tk && m_ctrl[3] && (m_t2 == 255);
            m_pre = tk ? 0 : m_pre + 1;
            if (tk) m_t1 = w1 ? 0 : m_t1 + 1;
            if (tk && m_ctrl[3]) m_t2 = ov ? int'(m_rl) : m_t2 + 1;
            if (ov) m_pin = ~m_pin;
            m_f1 = w1 | (m_f1 & ~clr1);
            m_f2 = ov | (m_f2 & ~clr2);
            if (ctrl_we) m_ctrl = ctrl_wd;
            if (rl_we) m_rl = rl_wd;
        end
    end

    function automatic bit exp_irq1(input logic f, input logic [3:0] c);
        return f & c[0];
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // per-cycle comparison on the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R6 tpin", tpin, m_pin);
            check("R3 flag1", flag1, m_f1);
            check("R5 flag2", flag2, m_f2);
            check("R7 irq1", irq1, exp_irq1(m_f1, m_ctrl));
            check("R7 ctrl", ctrl_o, m_ctrl);
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
        ctrl_we = 1'b0; rl_we = 1'b0; clr1 = 1'b0; clr2 = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ctrl_we = 1'b0; rl_we = 1'b0; clr1 = 1'b0; clr2 = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    initial begin : main
        int n, first, second;
        logic p0;
        void'($urandom(32'd2024));
        do_reset();
        // R9: reset values
        check("R9 ctrl", ctrl_o, 0);
        check("R9 flags", {flag1, flag2, irq1, tpin}, 0);

        // R1 R2: first wrap at rising edge 762
        n = 0;
        while (!flag1 && n < 1000) begin
            @(posedge clk); #1; n++;
        end
        check("R2 first wrap edge", n, 762);
        // R8: flag 1 sticky until cleared
        repeat (50) step();
        check("R8 sticky", flag1, 1);
        clr1 = 1'b1; step();
        check("R8 cleared", flag1, 0);

        // R4: stopped reload counter, bits 1 and 2 set
        ctrl_we = 1'b1; ctrl_wd = 4'b0110; step();
        p0 = tpin;
        repeat (3000) step();
        check("R4 pin stopped", tpin, p0);
        check("R4 flag2 stopped", flag2, 0);
        check("R7 ctrl stored", ctrl_o, 4'b0110);

        // R5 R10: reload 250 written while counting from 0
        do_reset();
        ctrl_we = 1'b1; ctrl_wd = 4'b1001; step();
        repeat (600) step();
        rl_we = 1'b1; rl_wd = 8'd250; step();
        n = 0;
        while (!flag2 && n < 3000) begin step(); n++; end
        first = n;
        clr2 = 1'b1; step();
        n = 0;
        while (!flag2 && n < 3000) begin step(); n++; end
        second = n + 1;
        check("R10 first overflow after 256 ticks", first + 602, 256 * 6);
        check("R5 reload period", second, 6 * 6);

        // random phase (mixed ops, model comparison each cycle)
        for (int i = 0; i < 40000; i++) begin
            if ($urandom_range(199) == 0) begin
                ctrl_we = 1'b1;
                ctrl_wd = 4'($urandom_range(15));
                if ($urandom_range(3) != 0) ctrl_wd[3] = 1'b1;
            end
            if ($urandom_range(299) == 0) begin
                rl_we = 1'b1;
                rl_wd = 8'($urandom_range(255, 200));
            end
            clr1 = ($urandom_range(49) == 0);
            clr2 = ($urandom_range(19) == 0);
            step();
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        #(190000 * 4);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule